// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one processor for a vector space of 256 entries. It holds three 256-bit vector-indexed registers. The request set marks vectors that have been raised and not yet taken. The service set marks vectors the processor is currently handling. The trigger set records whether each vector was last raised as level or edge.

Sources raise a vector with a one-cycle request strobe. The block drives a pending line to the processor whenever a request outranks the current processor priority. The processor takes an interrupt with an acknowledge strobe; in that same cycle it reads the vector to service from `ack_vector`. It retires the interrupt with an end-of-interrupt strobe, which releases the highest vector in service.

Software can program a task priority and a spurious vector register, the second of which carries the enable bit. Software can read every register through a 32-bit slice port. The processor priority is derived from the task priority and from the highest vector in service.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset the request, service and trigger sets are all clear, the task priority is 0 and the spurious register reads 0x0FF, so the block starts software-disabled.
- R2: Reads use `rd_sel` 0 for the request set, 1 for the service set and 2 for the trigger set. `rd_word` picks word w, and bit b of that word is vector 32*w+b. `rd_sel` 3 returns the 8-bit task priority, 4 returns the processor priority and 5 returns the 9-bit spurious register. Any other `rd_sel` value reads 0.
- R3: A request strobe sets the vector's request bit. It also sets the vector's trigger bit when `req_level` is 1 and clears it when `req_level` is 0.
- R4: `irq_pending` is 1 only if spurious bit 8 is set and the request set is non-empty. Even then it is 0 when the processor priority is nonzero and the upper nibble of the highest request is at most the upper nibble of the processor priority.
- R5: An acknowledge is blocked when the request set is empty, or when the task priority is nonzero and the highest request vector is at most the full 8-bit task priority. A blocked acknowledge returns spurious bits 7:0 and leaves the request and service sets unchanged.
- R6: An acknowledge that is not blocked returns the highest request vector, clears its request bit and sets its service bit.
- R7: End-of-interrupt clears the highest set service bit. With the service set empty it changes nothing.
- R8: A spurious write stores only the low 9 bits of the written value. Bit 8 is the software enable and bits 7:0 are the spurious vector.
- R9: A task-priority write of 4 bits is stored as value*16. `tpr_rdata` returns the upper nibble of the stored priority.
- R10: The processor priority equals the task priority when the task priority's upper nibble is at least the upper nibble of the highest service vector, taken as 0 when the service set is empty. Otherwise it equals that service vector with its low nibble cleared.
- R11: In one cycle, end-of-interrupt is applied first, then the acknowledge, then the request strobe. A request for the vector being acknowledged therefore leaves its request bit set while its service bit also sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Vector being raised |
| req_level | input | 1 | 1 for level-triggered, 0 for edge |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_vector | output | 8 | Vector returned for an acknowledge in the same cycle |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 4 | Task-priority class to write |
| tpr_rdata | output | 4 | Upper nibble of the task priority |
| svr_we | input | 1 | Spurious register write strobe |
| svr_wdata | input | 9 | Spurious register write value |
| rd_sel | input | 3 | Register select for slice reads |
| rd_word | input | 3 | Word index within a 256-bit set |
| rd_data | output | 32 | Read slice |
| irq_pending | output | 1 | Interrupt request to the processor |

## Verification
`ack_vector`, `irq_pending`, `tpr_rdata` and `rd_data` are combinational views of the current registers and inputs, so each one is due in the same cycle as the inputs that select it. Every state change made by a strobe shows on those outputs one clock edge later. The bench drives inputs just after the falling edge and compares all outputs against a behavioural model shortly afterwards. The model is advanced only after the next rising edge. A check therefore always sees state that includes every edge up to the stimulus, and none beyond it.

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
  parameter int VEC_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VEC_W-1:0]       req_vector,
  input  logic                   req_level,
  input  logic                   ack,
  output logic [VEC_W-1:0]       ack_vector,
  input  logic                   eoi,
  input  logic                   tpr_we,
  input  logic [VEC_W-5:0]       tpr_wdata,
  output logic [VEC_W-5:0]       tpr_rdata,
  input  logic                   svr_we,
  input  logic [VEC_W:0]         svr_wdata,
  input  logic [2:0]             rd_sel,
  input  logic [$clog2((2**VEC_W)/WORD_W)-1:0] rd_word,
  output logic [WORD_W-1:0]      rd_data,
  output logic                   irq_pending
);
  localparam int NVEC   = 2**VEC_W;
  localparam int NWORDS = NVEC / WORD_W;
  localparam int CLS_W  = VEC_W - 4;

  logic [NVEC-1:0]  irr_q, isr_q, tmr_q;
  logic [NVEC-1:0]  irr_n, isr_n, tmr_n;
  logic [VEC_W-1:0] tpr_q;
  logic [VEC_W:0]   svr_q;

  function automatic logic [VEC_W:0] find_top(input logic [NVEC-1:0] v);
    logic [NWORDS-1:0] word_hit;
    logic [WORD_W-1:0] w;
    logic [VEC_W:0]    r;
    int                wi;
    for (int i = 0; i < NWORDS; i++) word_hit[i] = |v[i*WORD_W +: WORD_W];
    wi = 0;
    for (int i = 0; i < NWORDS; i++) if (word_hit[i]) wi = i;
    w = v[wi*WORD_W +: WORD_W];
    r = '0;
    for (int j = 0; j < WORD_W; j++)
      if (w[j]) r = {1'b1, VEC_W'(wi*WORD_W + j)};
    return r;
  endfunction

  logic [VEC_W:0]   irr_find, isr_find;
  logic             irr_v, isr_v;
  logic [VEC_W-1:0] irr_top, isr_top;
  logic [CLS_W-1:0] isr_cls;
  logic [VEC_W-1:0] ppr;
  logic             ack_take;

  assign irr_find = find_top(irr_q);
  assign isr_find = find_top(isr_q);
  assign irr_v    = irr_find[VEC_W];
  assign irr_top  = irr_find[VEC_W-1:0];
  assign isr_v    = isr_find[VEC_W];
  assign isr_top  = isr_find[VEC_W-1:0];

  assign isr_cls  = isr_v ? isr_top[VEC_W-1:4] : '0;
  assign ppr      = (tpr_q[VEC_W-1:4] >= isr_cls) ? tpr_q : {isr_cls, 4'h0};

  assign ack_take   = irr_v && !((tpr_q != '0) && (irr_top <= tpr_q));
  assign ack_vector = ack_take ? irr_top : svr_q[VEC_W-1:0];

  assign irq_pending = svr_q[VEC_W] && irr_v &&
                       !((ppr != '0) && (irr_top[VEC_W-1:4] <= ppr[VEC_W-1:4]));

  assign tpr_rdata = tpr_q[VEC_W-1:4];

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    tmr_n = tmr_q;
    if (eoi && isr_v) isr_n[isr_top] = 1'b0;
    if (ack && ack_take) begin
      irr_n[irr_top] = 1'b0;
      isr_n[irr_top] = 1'b1;
    end
    if (req_valid) begin
      irr_n[req_vector] = 1'b1;
      tmr_n[req_vector] = req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
      tpr_q <= '0;
      svr_q <= {1'b0, {VEC_W{1'b1}}};
    end else begin
      irr_q <= irr_n;
      isr_q <= isr_n;
      tmr_q <= tmr_n;
      if (tpr_we) tpr_q <= {tpr_wdata, 4'h0};
      if (svr_we) svr_q <= svr_wdata;
    end
  end

  always_comb begin
    case (rd_sel)
      3'd0:    rd_data = irr_q[rd_word*WORD_W +: WORD_W];
      3'd1:    rd_data = isr_q[rd_word*WORD_W +: WORD_W];
      3'd2:    rd_data = tmr_q[rd_word*WORD_W +: WORD_W];
      3'd3:    rd_data = WORD_W'(tpr_q);
      3'd4:    rd_data = WORD_W'(ppr);
      3'd5:    rd_data = WORD_W'(svr_q);
      default: rd_data = '0;
    endcase
  end

  assert_req_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> irr_q[$past(req_vector)] && (tmr_q[$past(req_vector)] == $past(req_level)));

  assert_pend_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> svr_q[VEC_W] && (irr_q != '0));

  assert_blocked_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_take && !req_valid && !eoi) |=> $stable(irr_q) && $stable(isr_q));

  assert_ack_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_take) |=> isr_q[$past(ack_vector)]);

  assert_eoi_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_v && !ack) |=> !isr_q[$past(isr_top)]);
endmodule

// File: tb/intr_prio_ctrl_bench.sv
module intr_prio_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_level = 0, ack = 0, eoi = 0, tpr_we = 0, svr_we = 0;
  logic [7:0]  req_vector = 0;
  logic [3:0]  tpr_wdata = 0;
  logic [8:0]  svr_wdata = 0;
  logic [2:0]  rd_sel = 0, rd_word = 0;
  logic [7:0]  ack_vector;
  logic [3:0]  tpr_rdata;
  logic [31:0] rd_data;
  logic        irq_pending;

  int nchk = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_prio_ctrl u_intr_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
    .req_level(req_level), .ack(ack), .ack_vector(ack_vector), .eoi(eoi),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_rdata(tpr_rdata),
    .svr_we(svr_we), .svr_wdata(svr_wdata), .rd_sel(rd_sel), .rd_word(rd_word),
    .rd_data(rd_data), .irq_pending(irq_pending));

  logic [255:0] m_irr = '0, m_isr = '0, m_tmr = '0;
  int m_tpr = 0, m_svr = 'hFF;

  function automatic int top(input logic [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int m_ppr();
    int hs = top(m_isr);
    int ic = (hs < 0) ? 0 : hs / 16;
    return (m_tpr / 16 >= ic) ? m_tpr : ic * 16;
  endfunction

  function automatic bit m_take();
    int hi = top(m_irr);
    return (hi >= 0) && !(m_tpr != 0 && hi <= m_tpr);
  endfunction

  function automatic int m_rd(input int sel, input int w);
    case (sel)
      0: return int'(m_irr[w*32 +: 32]);
      1: return int'(m_isr[w*32 +: 32]);
      2: return int'(m_tmr[w*32 +: 32]);
      3: return m_tpr;
      4: return m_ppr();
      5: return m_svr;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rv, input int rvec, input bit rl, input bit a, input bit e,
                     input bit tw, input int twd, input bit sw, input int swd,
                     input int sel, input int w, input string rtag);
    int hi, hs, p;
    bit exp_pend, tk;
    @(negedge clk);
    req_valid = rv; req_vector = 8'(rvec); req_level = rl; ack = a; eoi = e;
    tpr_we = tw; tpr_wdata = 4'(twd); svr_we = sw; svr_wdata = 9'(swd);
    rd_sel = 3'(sel); rd_word = 3'(w);
    #1;
    hi = top(m_irr); p = m_ppr(); tk = m_take();
    exp_pend = m_svr[8] && hi >= 0 && !(p != 0 && hi / 16 <= p / 16);
    check("R4 irq_pending", int'(irq_pending), int'(exp_pend));
    check("R9 tpr_rdata", int'(tpr_rdata), m_tpr / 16);
    check(rtag, int'(rd_data), m_rd(sel, w));
    if (a) check(tk ? "R6 ack_vector" : "R5 ack_vector", int'(ack_vector), tk ? hi : (m_svr & 'hFF));
    @(posedge clk);
    hs = top(m_isr);
    if (e && hs >= 0) m_isr[hs] = 1'b0;
    if (a && tk) begin m_irr[hi] = 1'b0; m_isr[hi] = 1'b1; end
    if (rv) begin m_irr[rvec] = 1'b1; m_tmr[rvec] = rl; end
    if (tw) m_tpr = (twd & 'hF) * 16;
    if (sw) m_svr = swd & 'h1FF;
  endtask

  task automatic rd(input int sel, input int w, input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, sel, w, tag);
  endtask

  task automatic req(input int v, input bit lvl, input int sel, input int w, input string tag);
    cyc(1, v, lvl, 0, 0, 0, 0, 0, 0, sel, w, tag);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++) rd(s, w, "R1 set clear");
    rd(3, 0, "R1 tpr"); rd(5, 0, "R1 svr");
    // disabled: request raises no pending (R4)
    req(40, 0, 0, 1, "R3 irr word1");
    rd(0, 1, "R2 vector 40 at word1 bit8");
    // R8 masking and enable
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 'h3AB, 5, 0, "R8 svr");
    rd(5, 0, "R8 svr masked");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 'h1F0, 5, 0, "R8 svr");
    rd(0, 1, "R4 enabled pending");
    req(255, 1, 2, 7, "R3 tmr");
    rd(2, 7, "R3 tmr level set");
    req(255, 0, 2, 7, "R3 tmr");
    rd(2, 7, "R3 tmr edge clear");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 7, "R6 isr");
    rd(1, 7, "R6 isr word7");
    rd(4, 0, "R10 ppr from isr");
    rd(0, 7, "R6 irr cleared");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 7, "R7 isr");
    rd(1, 7, "R7 eoi cleared");
    cyc(0, 0, 0, 0, 0, 1, 3, 0, 0, 3, 0, "R9 tpr");
    rd(3, 0, "R9 tpr stored x16");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, "R5 irr");
    rd(0, 1, "R5 irr unchanged");
    rd(1, 1, "R5 isr unchanged");
    cyc(0, 0, 0, 0, 0, 1, 2, 0, 0, 4, 0, "R10 ppr");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 4, 0, "R10 ppr");
    rd(4, 0, "R10 ppr tpr wins");
    rd(1, 1, "R6 isr word1");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, "R7 isr");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 1, "R7 empty eoi");
    rd(1, 1, "R7 empty eoi no change");
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 empty ack");
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 3, 0, "R9 tpr");
    req(100, 0, 0, 3, "R3 irr");
    cyc(1, 100, 1, 1, 0, 0, 0, 0, 0, 0, 3, "R11 irr");
    rd(0, 3, "R11 irr kept");
    rd(1, 3, "R11 isr set");
    req(0, 0, 0, 0, "R3 irr"); req(31, 1, 0, 0, "R3 irr"); req(32, 0, 0, 1, "R3 irr");
    rd(0, 0, "R2 vectors 0 and 31"); rd(0, 1, "R2 vector 32"); rd(2, 0, "R2 tmr 31");
    for (int k = 0; k < 4000; k++) begin
      int sel = $urandom_range(0, 6);
      cyc(($urandom_range(0, 3) == 0), $urandom_range(0, 255), $urandom_range(0, 1),
          ($urandom_range(0, 4) == 0), ($urandom_range(0, 4) == 0),
          ($urandom_range(0, 30) == 0), $urandom_range(0, 15),
          ($urandom_range(0, 60) == 0), $urandom_range(0, 511) | 'h100,
          sel, $urandom_range(0, 7), sel < 3 ? "R2 rand set" : "R10 rand reg");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule